// File: doc/BRIEF.md
# 1-Wire Search Triplet Sequencer

This block runs one step of the 1-Wire ROM search algorithm for each start request. It asks a bit-level bus engine for two read slots, first the ID bit and then its complement. From those two bits and a direction supplied by the caller, it picks the branch to follow. It then asks the engine for one write slot that puts the chosen direction on the bus. When the step ends, the block returns a 3-bit result code and raises a one-cycle done pulse.

The block does not track the 64-bit search path or the last-discrepancy position. The caller keeps that state and calls the sequencer once per ROM bit. The bus engine sits below the block and performs the actual slot timing. The two are joined by a request/acknowledge handshake, in which the engine may report a failure in place of an acknowledge.

Top module: `trip_search_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `slot_req_o` are 0, and `result_o` is 3'b000.
- R2: An accepted start produces bus slots in a fixed order: a read (`slot_wr_o`=0) for the ID bit, then a read for the complement bit, then at most one write (`slot_wr_o`=1).
- R3: If both bits read 1, the block issues no write slot and finishes right after the second read with `result_o`=3'b011 and `err_o`=0.
- R4: If both bits read 0, the caller's direction `dir_i` (sampled at start) is written, and the result is 3'b100 for direction 1 or 3'b000 for direction 0.
- R5: If exactly one bit reads 1, the ID bit is written regardless of `dir_i`, and the result is 3'b101 when the ID bit is 1 or 3'b010 when it is 0.
- R6: The result fields are: bit 0 = ID bit, bit 1 = complement bit, bit 2 = direction taken.
- R7: If the engine signals `slot_fail_i` on any slot, the block issues no further slots and finishes with `result_o`=3'b011 and `err_o`=1.
- R8: A start raised while `busy_o` is 1 has no effect. It adds no slot, and the direction used is not changed.
- R9: `done_o` is a one-cycle pulse and `busy_o` is 0 during it. A start sampled in that same cycle is accepted. `result_o` and `err_o` hold their values until the next done.
- R10: `slot_req_o`, `slot_wr_o` and `slot_wdat_o` stay stable from the request until the engine answers with `slot_ack_i` or `slot_fail_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start one triplet |
| dir_i | input | 1 | Requested direction, used when both bits read 0 |
| busy_o | output | 1 | Triplet in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last triplet aborted on engine failure |
| result_o | output | 3 | {direction, complement bit, ID bit} |
| slot_req_o | output | 1 | Slot request to the bit engine |
| slot_wr_o | output | 1 | 1 = write slot, 0 = read slot |
| slot_wdat_o | output | 1 | Bit to write |
| slot_ack_i | input | 1 | Engine finished the slot |
| slot_rdat_i | input | 1 | Bit read, valid with `slot_ack_i` |
| slot_fail_i | input | 1 | Engine error or timeout on the slot |

## Verification
The case of interest is a start request that meets the block while it is finishing a triplet. A pulse on `start_i` in the middle of a run must be dropped. A start held during the done cycle must begin a fresh triplet at once. The bench raises start in the middle of a run with the opposite direction. It then confirms that the same three slots occur, that the original direction is written and that no second done follows. It also raises start exactly on the done pulse and expects six slots and two results in total.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int RES_W = 3;
  localparam logic [RES_W-1:0] RES_NONE = 3'b011;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_ID,
    ST_RD_CMP,
    ST_WR_DIR
  } trip_state_e;
endpackage

// File: rtl/trip_decide.sv
module trip_decide
  import trip_pkg::*;
(
  input  logic             id_bit,
  input  logic             cmp_bit,
  input  logic             dir_req,
  output logic             no_slave,
  output logic             wr_dir,
  output logic [RES_W-1:0] code
);
  always_comb begin
    no_slave = id_bit & cmp_bit;
    // differing bits force the branch; equal zeros take the request
    wr_dir   = (id_bit ^ cmp_bit) ? id_bit : dir_req;
    code     = no_slave ? RES_NONE : {wr_dir, cmp_bit, id_bit};
  end
endmodule

// File: rtl/trip_slot_if.sv
module trip_slot_if (
  input  logic clk,
  input  logic rst,
  input  logic issue_i,
  input  logic issue_wr_i,
  input  logic issue_bit_i,
  output logic req_o,
  output logic wr_o,
  output logic wdat_o,
  input  logic ack_i,
  input  logic rdat_i,
  input  logic fail_i,
  output logic fin_o,
  output logic fin_bit_o,
  output logic fin_err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o     <= 1'b0;
      wr_o      <= 1'b0;
      wdat_o    <= 1'b0;
      fin_o     <= 1'b0;
      fin_bit_o <= 1'b0;
      fin_err_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (issue_i) begin
        req_o  <= 1'b1;
        wr_o   <= issue_wr_i;
        wdat_o <= issue_bit_i;
      end else if (req_o && (ack_i || fail_i)) begin
        req_o     <= 1'b0;
        fin_o     <= 1'b1;
        fin_bit_o <= rdat_i;
        fin_err_o <= fail_i;
      end
    end
  end

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i && !fail_i) |=> (req_o && $stable(wr_o) && $stable(wdat_o)));

  // R10
  no_reissue_chk: assert property (@(posedge clk) disable iff (rst)
    issue_i |-> !req_o);
endmodule

// File: rtl/trip_ctrl.sv
module trip_ctrl
  import trip_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic             fin_i,
  input  logic             fin_bit_i,
  input  logic             fin_err_i,
  output logic             issue_o,
  output logic             issue_wr_o,
  output logic             issue_bit_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [RES_W-1:0] result_o
);
  trip_state_e      st;
  logic             id_q;
  logic             dir_q;
  logic [RES_W-1:0] pend_q;
  logic             no_slave;
  logic             wr_dir;
  logic [RES_W-1:0] code;

  trip_decide u_decide (
    .id_bit   (id_q),
    .cmp_bit  (fin_bit_i),
    .dir_req  (dir_q),
    .no_slave (no_slave),
    .wr_dir   (wr_dir),
    .code     (code)
  );

  always_comb begin
    issue_o     = 1'b0;
    issue_wr_o  = 1'b0;
    issue_bit_o = 1'b0;
    case (st)
      ST_IDLE:   issue_o = start_i;
      ST_RD_ID:  issue_o = fin_i && !fin_err_i;
      ST_RD_CMP: begin
        issue_o     = fin_i && !fin_err_i && !no_slave;
        issue_wr_o  = 1'b1;
        issue_bit_o = wr_dir;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      result_o <= '0;
      id_q     <= 1'b0;
      dir_q    <= 1'b0;
      pend_q   <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          busy_o <= 1'b1;
          dir_q  <= dir_i;
          st     <= ST_RD_ID;
        end
        ST_RD_ID: if (fin_i) begin
          if (fin_err_i) begin
            st <= ST_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
            err_o <= 1'b1; result_o <= RES_NONE;
          end else begin
            id_q <= fin_bit_i;
            st   <= ST_RD_CMP;
          end
        end
        ST_RD_CMP: if (fin_i) begin
          if (fin_err_i || no_slave) begin
            st <= ST_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
            err_o <= fin_err_i; result_o <= RES_NONE;
          end else begin
            pend_q <= code;
            st     <= ST_WR_DIR;
          end
        end
        ST_WR_DIR: if (fin_i) begin
          st <= ST_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
          err_o    <= fin_err_i;
          result_o <= fin_err_i ? RES_NONE : pend_q;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R7
  abort_code_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (result_o == RES_NONE));

  // R8
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(dir_q));
endmodule

// File: rtl/trip_search_seq.sv
module trip_search_seq
  import trip_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             dir_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [RES_W-1:0] result_o,
  output logic             slot_req_o,
  output logic             slot_wr_o,
  output logic             slot_wdat_o,
  input  logic             slot_ack_i,
  input  logic             slot_rdat_i,
  input  logic             slot_fail_i
);
  logic issue, issue_wr, issue_bit;
  logic fin, fin_bit, fin_err;

  trip_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .dir_i       (dir_i),
    .fin_i       (fin),
    .fin_bit_i   (fin_bit),
    .fin_err_i   (fin_err),
    .issue_o     (issue),
    .issue_wr_o  (issue_wr),
    .issue_bit_o (issue_bit),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .result_o    (result_o)
  );

  trip_slot_if u_slot (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue),
    .issue_wr_i  (issue_wr),
    .issue_bit_i (issue_bit),
    .req_o       (slot_req_o),
    .wr_o        (slot_wr_o),
    .wdat_o      (slot_wdat_o),
    .ack_i       (slot_ack_i),
    .rdat_i      (slot_rdat_i),
    .fail_i      (slot_fail_i),
    .fin_o       (fin),
    .fin_bit_o   (fin_bit),
    .fin_err_o   (fin_err)
  );

  // R2
  req_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    slot_req_o |-> busy_o);
endmodule

// File: tb/trip_search_seq_test.sv
module trip_search_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic dir_i = 1'b0;
  logic busy_o, done_o, err_o;
  logic [2:0] result_o;
  logic slot_req_o, slot_wr_o, slot_wdat_o;
  logic slot_ack_i = 1'b0;
  logic slot_rdat_i = 1'b0;
  logic slot_fail_i = 1'b0;

  int checks = 0;
  int errors = 0;

  // bus engine model state
  int lat = 0;
  int fail_at = -1;
  logic id_v = 1'b0;
  logic cmp_v = 1'b0;
  int slot_idx = 0;
  int wr_cnt = 0;
  logic wr_bit = 1'b0;
  int cnt = 0;
  int order_bad = 0;

  always #10 clk = ~clk;

  trip_search_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .result_o(result_o),
    .slot_req_o(slot_req_o), .slot_wr_o(slot_wr_o), .slot_wdat_o(slot_wdat_o),
    .slot_ack_i(slot_ack_i), .slot_rdat_i(slot_rdat_i), .slot_fail_i(slot_fail_i)
  );

  always @(negedge clk) begin
    if (slot_ack_i || slot_fail_i) begin
      slot_ack_i = 1'b0;
      slot_fail_i = 1'b0;
    end else if (slot_req_o) begin
      if (cnt >= lat) begin
        if ((slot_idx % 3) < 2 && slot_wr_o) order_bad++;
        if ((slot_idx % 3) == 2 && !slot_wr_o) order_bad++;
        slot_rdat_i = ((slot_idx % 3) == 0) ? id_v : cmp_v;
        if (slot_idx == fail_at) slot_fail_i = 1'b1;
        else begin
          slot_ack_i = 1'b1;
          if (slot_wr_o) begin wr_cnt++; wr_bit = slot_wdat_o; end
        end
        slot_idx++;
        cnt = 0;
      end else cnt++;
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic arm(input logic id, input logic cmp, input int l, input int f);
    id_v = id; cmp_v = cmp; lat = l; fail_at = f;
    slot_idx = 0; wr_cnt = 0; cnt = 0; order_bad = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_o) begin seen = 1; break; end
    end
  endtask

  task automatic run(input logic id, input logic cmp, input logic dir, input int l);
    bit seen;
    int exp_res, exp_wr, exp_bit, exp_slots;
    arm(id, cmp, l, -1);
    @(negedge clk); start_i = 1'b1; dir_i = dir;
    @(negedge clk); start_i = 1'b0;
    wait_done(seen);
    if (id && cmp) begin
      exp_res = 3; exp_wr = 0; exp_bit = 0; exp_slots = 2;          // R3
    end else if (!id && !cmp) begin
      exp_bit = dir; exp_res = dir * 4; exp_wr = 1; exp_slots = 3;  // R4
    end else begin
      exp_bit = id; exp_res = id * 4 + cmp * 2 + id; exp_wr = 1; exp_slots = 3; // R5
    end
    check(seen, "R9 done seen", seen, 1);
    check(result_o == exp_res, "R6 result code", result_o, exp_res);
    check(err_o == 1'b0, "R3 err low", err_o, 0);
    check(wr_cnt == exp_wr, "R3 write count", wr_cnt, exp_wr);
    if (exp_wr == 1) check(wr_bit == exp_bit, "R5 written bit", wr_bit, exp_bit);
    check(slot_idx == exp_slots, "R2 slot count", slot_idx, exp_slots);
    check(order_bad == 0, "R2 slot order", order_bad, 0);
    check(!busy_o, "R9 busy low at done", busy_o, 0);
    @(negedge clk);
    check(!done_o, "R9 done one cycle", done_o, 0);
    check(result_o == exp_res, "R9 result held", result_o, exp_res);
  endtask

  task automatic run_fail(input int f);
    bit seen;
    arm(1'b0, 1'b0, 1, f);
    @(negedge clk); start_i = 1'b1; dir_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done(seen);
    check(seen, "R7 done on fail", seen, 1);
    check(result_o == 3'b011, "R7 abort code", result_o, 3);
    check(err_o == 1'b1, "R7 err flag", err_o, 1);
    check(slot_idx == f + 1, "R7 no further slots", slot_idx, f + 1);
    for (int i = 0; i < 5; i++) @(negedge clk);
    check(slot_idx == f + 1 && !busy_o, "R7 stays idle", slot_idx, f + 1);
  endtask

  initial begin
    bit seen;
    int dones;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && !err_o && !slot_req_o, "R1 reset flags",
          {busy_o, done_o, err_o, slot_req_o}, 0);
    check(result_o == 3'b000, "R1 reset result", result_o, 0);

    // R2 R3 R4 R5 R6: full sweep over bits, direction and engine latency
    for (int l = 0; l < 3; l += 2)
      for (int v = 0; v < 8; v++)
        run(v[0], v[1], v[2], l);

    // R7: failure on each slot
    for (int f = 0; f < 3; f++) run_fail(f);
    // R7 cleared by a clean run
    run(1'b1, 1'b0, 1'b0, 0);

    // R8: start pulsed mid-run with the other direction
    arm(1'b0, 1'b0, 3, -1);
    @(negedge clk); start_i = 1'b1; dir_i = 1'b1;
    @(negedge clk); start_i = 1'b0; dir_i = 1'b0;
    @(negedge clk); @(negedge clk);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done(seen);
    check(result_o == 3'b100, "R8 direction kept", result_o, 4);
    check(wr_bit == 1'b1, "R8 written bit kept", wr_bit, 1);
    dones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    check(slot_idx == 3 && dones == 0, "R8 no extra run", slot_idx, 3);

    // R9: start held in the done cycle is accepted
    arm(1'b0, 1'b1, 0, -1);
    @(negedge clk); start_i = 1'b1; dir_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done(seen);
    check(result_o == 3'b010, "R9 first result", result_o, 2);
    start_i = 1'b1; dir_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o, "R9 restart on done", busy_o, 1);
    wait_done(seen);
    check(seen && slot_idx == 6, "R9 second run slots", slot_idx, 6);
    check(result_o == 3'b010, "R9 second result", result_o, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule